// File: doc/BRIEF.md
# Dual-Core Boot Hold Controller

This block sequences the low-power states of a two-processor system. After reset the primary core runs and the secondary core sits in a stop state with its boot held. The secondary core starts only when software writes a release bit or a boot-option strap is tied high. The block keeps a registered status code for each core. It moves each core between run, sleep and stop as that core requests, and it controls a shared standby state.

Secondary-core wake-up events need care. While the release bit is clear, such an event wakes the primary core so that the primary core can initialize the system. The event is then held as pending and reaches the secondary core once release is seen. Accesses aimed at the held secondary core are flagged as illegal when the strap is low. The flag is sticky until a write-one-to-clear strobe.

Top module: `bhc_boot_hold_ctrl`

## Requirements
- R1: Synchronous active-high reset gives primary status run and secondary status held, with no wake pulses, the illegal flag clear and standby clear. The status codes are 2'b00 run, 2'b01 sleep, 2'b10 stop and 2'b11 stop with boot held.
- R2: A held secondary core outside standby goes to run on the next edge when the release bit or the strap is 1. Any exit of the secondary core from stop or held to run pulses its wake output for one cycle. While standby is active, the secondary core stays held even when released.
- R3: A primary stop request is not granted while the secondary core is held and the release bit is 1. The primary core stays in run or sleep for that cycle.
- R4: In run or sleep, the primary core goes to stop on a granted stop request, otherwise to sleep on a sleep request, otherwise to run. A primary wake source moves it from stop to run and pulses its wake output.
- R5: When release (bit or strap) is 0, a secondary wake source or a pending secondary wake moves a stopped primary core to run with a wake pulse. The secondary core stays in stop or held.
- R6: A secondary wake that cannot be delivered is latched as pending. Once released, with no primary wake in the same cycle, the secondary core goes to run.
- R7: If primary and secondary wake sources fire in the same cycle, the primary core wakes first. The secondary wake stays pending and is delivered one cycle later.
- R8: A standby request is honoured only when the secondary core is held, or when both cores are stopped. Standby reports primary stop and secondary held. Any wake source ends standby with the primary core in run. The secondary core goes to run only if its own source fired while released and no primary source fired; otherwise it stays held.
- R9: With the strap at 0, an access while the secondary core is held sets the illegal flag. An access while the core is not held, or with the strap at 1, leaves the flag unchanged.
- R10: In the secondary core, run and sleep go to stop on a stop request, otherwise to sleep on a sleep request, otherwise to run.
- R11: The illegal flag holds until a clear strobe. A new illegal access in the same cycle as the clear strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rel_bit_i | input | 1 | Software boot-release bit |
| strap_i | input | 1 | Boot-option strap; 1 releases the secondary core |
| pri_sleep_req_i | input | 1 | Primary core sleep request |
| pri_stop_req_i | input | 1 | Primary core stop request |
| sec_sleep_req_i | input | 1 | Secondary core sleep request |
| sec_stop_req_i | input | 1 | Secondary core stop request |
| standby_req_i | input | 1 | System standby request |
| pri_wake_i | input | PRI_SRC | Primary core wake sources |
| sec_wake_i | input | SEC_SRC | Secondary core wake sources |
| sec_access_i | input | 1 | Access targeting the secondary core |
| illegal_clr_i | input | 1 | Write-one-to-clear strobe for the illegal flag |
| pri_state_o | output | 2 | Primary core status code |
| sec_state_o | output | 2 | Secondary core status code |
| pri_wake_o | output | 1 | One-cycle primary wake pulse |
| sec_wake_o | output | 1 | One-cycle secondary wake pulse |
| illegal_o | output | 1 | Sticky illegal-access flag |
| standby_o | output | 1 | Standby active |

## Verification
The bench targets the routing sequence. A secondary wake with release clear must wake the primary core. A design that forwards the event directly would start the secondary core with boot still held. The bench also drives same-cycle primary and secondary wakes, where a design without the pending latch would drop the secondary event. Other cases are a stop request in the one cycle where release is being seen, which a careless design grants, and standby requests from running states, which must be ignored. The bench checks that standby exit returns the secondary core to hold even with the strap high. It also covers a clear strobe that collides with a fresh illegal access, which a clear-first design would lose.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    CS_RUN   = 2'b00,
    CS_SLEEP = 2'b01,
    CS_STOP  = 2'b10,
    CS_HELD  = 2'b11
  } core_st_e;
endpackage

// File: rtl/bhc_wake_merge.sv
module bhc_wake_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] src,
  output logic         any
);
  logic [N:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign chain[i+1] = chain[i] | src[i];
  end
  assign any = chain[N];
endmodule

// File: rtl/bhc_primary_fsm.sv
module bhc_primary_fsm
  import bhc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sleep_req,
  input  logic     stop_req,
  input  logic     wake_any,
  input  logic     route_wake,
  input  logic     stop_block,
  input  logic     in_stby,
  input  logic     stby_enter,
  input  logic     stby_exit,
  output core_st_e state,
  output logic     wake_pulse
);
  core_st_e state_d;

  always_comb begin
    state_d = state;
    if (stby_enter) begin
      state_d = CS_STOP;
    end else if (stby_exit) begin
      state_d = CS_RUN;
    end else if (!in_stby) begin
      case (state)
        CS_RUN, CS_SLEEP: begin
          if (stop_req && !stop_block) state_d = CS_STOP;
          else if (sleep_req)          state_d = CS_SLEEP;
          else                         state_d = CS_RUN;
        end
        CS_STOP: begin
          if (wake_any || route_wake) state_d = CS_RUN;
        end
        default: state_d = CS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CS_RUN;
      wake_pulse <= 1'b0;
    end else begin
      state      <= state_d;
      wake_pulse <= (state == CS_STOP) && (state_d == CS_RUN);
    end
  end

  // R3: stop is deferred while the held core is being released
  p_stop_defer_r3: assert property (@(posedge clk) disable iff (rst)
    (state != CS_STOP && stop_req && stop_block && !stby_enter) |=> (state != CS_STOP));

  // R5: routed secondary wake brings the primary core out of stop
  p_route_r5: assert property (@(posedge clk) disable iff (rst)
    (state == CS_STOP && !in_stby && route_wake && !stby_enter) |=> (state == CS_RUN && wake_pulse));

  // R4: primary core is never reported as held
  p_never_held_r4: assert property (@(posedge clk) disable iff (rst)
    state != CS_HELD);
endmodule

// File: rtl/bhc_secondary_fsm.sv
module bhc_secondary_fsm
  import bhc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sleep_req,
  input  logic     stop_req,
  input  logic     wake_any,
  input  logic     pri_wake_any,
  input  logic     released,
  input  logic     in_stby,
  input  logic     stby_enter,
  input  logic     stby_exit,
  output core_st_e state,
  output logic     wake_pulse,
  output logic     pend
);
  core_st_e state_d;
  logic     deliver_ok;
  logic     low_state;
  logic     pend_d;

  assign deliver_ok = released && !pri_wake_any;
  assign low_state  = (state == CS_STOP) || (state == CS_HELD);

  always_comb begin
    state_d = state;
    if (stby_enter) begin
      state_d = CS_HELD;
    end else if (stby_exit) begin
      state_d = (wake_any && deliver_ok) ? CS_RUN : CS_HELD;
    end else if (!in_stby) begin
      case (state)
        CS_HELD:  if (released) state_d = CS_RUN;
        CS_STOP:  if ((wake_any || pend) && deliver_ok) state_d = CS_RUN;
        default: begin
          if (stop_req)       state_d = CS_STOP;
          else if (sleep_req) state_d = CS_SLEEP;
          else                state_d = CS_RUN;
        end
      endcase
    end
  end

  always_comb begin
    pend_d = pend;
    if (low_state && state_d == CS_RUN) pend_d = 1'b0;
    else if ((low_state || in_stby) && wake_any) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CS_HELD;
      wake_pulse <= 1'b0;
      pend       <= 1'b0;
    end else begin
      state      <= state_d;
      wake_pulse <= low_state && (state_d == CS_RUN);
      pend       <= pend_d;
    end
  end

  // R2: release takes a held core out of hold outside standby
  p_hold_release_r2: assert property (@(posedge clk) disable iff (rst)
    (state == CS_HELD && released && !in_stby && !stby_enter) |=> (state == CS_RUN && wake_pulse));

  // R6: a pending wake is delivered once released
  p_pend_deliver_r6: assert property (@(posedge clk) disable iff (rst)
    (state == CS_STOP && pend && released && !pri_wake_any && !in_stby && !stby_enter)
      |=> (state == CS_RUN));

  // R7: primary wins a same-cycle wake, secondary stays stopped
  p_prio_r7: assert property (@(posedge clk) disable iff (rst)
    (state == CS_STOP && !in_stby && !stby_enter && pri_wake_any && wake_any)
      |=> (state == CS_STOP && pend));

  // R2: the wake pulse only accompanies the run state
  p_pulse_run_r2: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (state == CS_RUN));
endmodule

// File: rtl/bhc_illegal_flag.sv
module bhc_illegal_flag (
  input  logic clk,
  input  logic rst,
  input  logic access,
  input  logic held,
  input  logic strap,
  input  logic clr,
  output logic flag
);
  logic hit;
  assign hit = access && held && !strap;

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R9: illegal access raises the flag
  p_set_r9: assert property (@(posedge clk) disable iff (rst)
    (access && held && !strap) |=> flag);

  // R11: the flag is sticky without a clear strobe
  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/bhc_boot_hold_ctrl.sv
module bhc_boot_hold_ctrl
  import bhc_pkg::*;
#(
  parameter int PRI_SRC = 4,
  parameter int SEC_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rel_bit_i,
  input  logic               strap_i,
  input  logic               pri_sleep_req_i,
  input  logic               pri_stop_req_i,
  input  logic               sec_sleep_req_i,
  input  logic               sec_stop_req_i,
  input  logic               standby_req_i,
  input  logic [PRI_SRC-1:0] pri_wake_i,
  input  logic [SEC_SRC-1:0] sec_wake_i,
  input  logic               sec_access_i,
  input  logic               illegal_clr_i,
  output logic [ST_W-1:0]    pri_state_o,
  output logic [ST_W-1:0]    sec_state_o,
  output logic               pri_wake_o,
  output logic               sec_wake_o,
  output logic               illegal_o,
  output logic               standby_o
);
  logic     pri_any, sec_any, released;
  logic     stby_q, stby_ok, stby_enter, stby_exit;
  logic     route_wake, stop_block, sec_pend;
  core_st_e pri_st, sec_st;

  bhc_wake_merge #(.N(PRI_SRC)) u_pri_merge (.src(pri_wake_i), .any(pri_any));
  bhc_wake_merge #(.N(SEC_SRC)) u_sec_merge (.src(sec_wake_i), .any(sec_any));

  assign released   = rel_bit_i || strap_i;
  assign stby_ok    = !stby_q && ((sec_st == CS_HELD) ||
                      (pri_st == CS_STOP && sec_st == CS_STOP));
  assign stby_enter = standby_req_i && stby_ok;
  assign stby_exit  = stby_q && (pri_any || sec_any);
  assign route_wake = (sec_any || sec_pend) && !released;
  assign stop_block = (sec_st == CS_HELD) && rel_bit_i;

  always_ff @(posedge clk) begin
    if (rst)             stby_q <= 1'b0;
    else if (stby_enter) stby_q <= 1'b1;
    else if (stby_exit)  stby_q <= 1'b0;
  end

  bhc_primary_fsm u_pri (
    .clk(clk), .rst(rst),
    .sleep_req(pri_sleep_req_i), .stop_req(pri_stop_req_i),
    .wake_any(pri_any), .route_wake(route_wake), .stop_block(stop_block),
    .in_stby(stby_q), .stby_enter(stby_enter), .stby_exit(stby_exit),
    .state(pri_st), .wake_pulse(pri_wake_o)
  );

  bhc_secondary_fsm u_sec (
    .clk(clk), .rst(rst),
    .sleep_req(sec_sleep_req_i), .stop_req(sec_stop_req_i),
    .wake_any(sec_any), .pri_wake_any(pri_any), .released(released),
    .in_stby(stby_q), .stby_enter(stby_enter), .stby_exit(stby_exit),
    .state(sec_st), .wake_pulse(sec_wake_o), .pend(sec_pend)
  );

  bhc_illegal_flag u_ill (
    .clk(clk), .rst(rst),
    .access(sec_access_i), .held(sec_st == CS_HELD), .strap(strap_i),
    .clr(illegal_clr_i), .flag(illegal_o)
  );

  assign pri_state_o = pri_st;
  assign sec_state_o = sec_st;
  assign standby_o   = stby_q;

  // R8: standby reports primary stopped and secondary held
  p_stby_states_r8: assert property (@(posedge clk) disable iff (rst)
    standby_o |-> (pri_st == CS_STOP && sec_st == CS_HELD));

  // R8: a request from running cores does not enter standby
  p_stby_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    (!stby_q && standby_req_i && pri_st != CS_STOP && sec_st != CS_HELD) |=> !standby_o);
endmodule

// File: tb/bhc_boot_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module bhc_boot_hold_ctrl_tb_top;
  localparam int PRI_SRC = 4;
  localparam int SEC_SRC = 4;
  localparam logic [1:0] RUN = 2'b00, SLP = 2'b01, STP = 2'b10, HLD = 2'b11;
  localparam int B_RST = 1, B_REL = 2, B_STRAP = 4, B_PSL = 8, B_PST = 16,
                 B_SSL = 32, B_SST = 64, B_SBY = 128, B_ACC = 256, B_CLR = 512,
                 B_PW = 1024, B_SW = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rel_bit_i = 0, strap_i = 0, pri_sleep_req_i = 0, pri_stop_req_i = 0;
  logic sec_sleep_req_i = 0, sec_stop_req_i = 0, standby_req_i = 0;
  logic [PRI_SRC-1:0] pri_wake_i = '0;
  logic [SEC_SRC-1:0] sec_wake_i = '0;
  logic sec_access_i = 0, illegal_clr_i = 0;
  logic [1:0] pri_state_o, sec_state_o;
  logic pri_wake_o, sec_wake_o, illegal_o, standby_o;

  int n_tests = 0, n_fail = 0, step_n = 0;
  bit done = 0;

  typedef struct {
    string req;
    logic [1:0] p, s;
    logic pw, sw, il, sb;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  bhc_boot_hold_ctrl #(.PRI_SRC(PRI_SRC), .SEC_SRC(SEC_SRC)) dut_i (
    .clk(clk), .rst(rst), .rel_bit_i(rel_bit_i), .strap_i(strap_i),
    .pri_sleep_req_i(pri_sleep_req_i), .pri_stop_req_i(pri_stop_req_i),
    .sec_sleep_req_i(sec_sleep_req_i), .sec_stop_req_i(sec_stop_req_i),
    .standby_req_i(standby_req_i), .pri_wake_i(pri_wake_i), .sec_wake_i(sec_wake_i),
    .sec_access_i(sec_access_i), .illegal_clr_i(illegal_clr_i),
    .pri_state_o(pri_state_o), .sec_state_o(sec_state_o),
    .pri_wake_o(pri_wake_o), .sec_wake_o(sec_wake_o),
    .illegal_o(illegal_o), .standby_o(standby_o)
  );

  // driver: applies one cycle of inputs and queues the expected outputs after that edge
  task automatic cyc(input string req, input int b, input logic [1:0] ep, input logic [1:0] es,
                     input logic epw, input logic esw, input logic eil, input logic esb);
    exp_t e;
    @(negedge clk);
    rst             = (b & B_RST) != 0;
    rel_bit_i       = (b & B_REL) != 0;
    strap_i         = (b & B_STRAP) != 0;
    pri_sleep_req_i = (b & B_PSL) != 0;
    pri_stop_req_i  = (b & B_PST) != 0;
    sec_sleep_req_i = (b & B_SSL) != 0;
    sec_stop_req_i  = (b & B_SST) != 0;
    standby_req_i   = (b & B_SBY) != 0;
    sec_access_i    = (b & B_ACC) != 0;
    illegal_clr_i   = (b & B_CLR) != 0;
    pri_wake_i      = ((b & B_PW) != 0) ? PRI_SRC'(1 << (step_n % PRI_SRC)) : '0;
    sec_wake_i      = ((b & B_SW) != 0) ? SEC_SRC'(1 << ((step_n + 1) % SEC_SRC)) : '0;
    step_n++;
    e.req = req; e.p = ep; e.s = es; e.pw = epw; e.sw = esw; e.il = eil; e.sb = esb;
    sb_q.push_back(e);
  endtask

  // monitor: compares just after each active edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_tests++;
      if (pri_state_o !== e.p || sec_state_o !== e.s || pri_wake_o !== e.pw ||
          sec_wake_o !== e.sw || illegal_o !== e.il || standby_o !== e.sb) begin
        n_fail++;
        $display("FAIL %s: got p=%b s=%b pw=%b sw=%b il=%b sb=%b exp p=%b s=%b pw=%b sw=%b il=%b sb=%b",
                 e.req, pri_state_o, sec_state_o, pri_wake_o, sec_wake_o, illegal_o, standby_o,
                 e.p, e.s, e.pw, e.sw, e.il, e.sb);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got running exp finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc("R1 reset",            B_RST, RUN, HLD, 0, 0, 0, 0);
    cyc("R1 reset held",       B_RST, RUN, HLD, 0, 0, 0, 0);
    cyc("R9 access held",      B_ACC, RUN, HLD, 0, 0, 1, 0);
    cyc("R11 sticky",          0,     RUN, HLD, 0, 0, 1, 0);
    cyc("R11 clear",           B_CLR, RUN, HLD, 0, 0, 0, 0);
    cyc("R4 pri sleep",        B_PSL, SLP, HLD, 0, 0, 0, 0);
    cyc("R4 pri back run",     0,     RUN, HLD, 0, 0, 0, 0);
    cyc("R6 sec wake latched", B_SW,  RUN, HLD, 0, 0, 0, 0);
    cyc("R2 release",          B_REL, RUN, RUN, 0, 1, 0, 0);
    cyc("R4 pri stop",         B_REL | B_PST, STP, RUN, 0, 0, 0, 0);
    cyc("R10 sec sleep",       B_REL | B_SSL, STP, SLP, 0, 0, 0, 0);
    cyc("R10 sec stop",        B_SST, STP, STP, 0, 0, 0, 0);
    cyc("R5 routed wake",      B_SW,  RUN, STP, 1, 0, 0, 0);
    cyc("R6 pending delivered", B_REL, RUN, RUN, 0, 1, 0, 0);
    cyc("R4 pri stop again",   B_REL | B_PST, STP, RUN, 0, 0, 0, 0);
    cyc("R10 sec stop again",  B_SST, STP, STP, 0, 0, 0, 0);
    cyc("R7 same-cycle wakes", B_REL | B_PW | B_SW, RUN, STP, 1, 0, 0, 0);
    cyc("R7 sec one later",    B_REL, RUN, RUN, 0, 1, 0, 0);
    cyc("R4 R10 both stop",    B_PST | B_SST, STP, STP, 0, 0, 0, 0);
    cyc("R8 standby enter",    B_SBY, STP, HLD, 0, 0, 0, 1);
    cyc("R8 standby stays",    0,     STP, HLD, 0, 0, 0, 1);
    cyc("R8 standby exit pri", B_PW,  RUN, HLD, 1, 0, 0, 0);
    cyc("R11 set beats clear", B_ACC | B_CLR, RUN, HLD, 0, 0, 1, 0);
    cyc("R11 clear again",     B_CLR, RUN, HLD, 0, 0, 0, 0);
    cyc("R8 standby from held", B_SBY, STP, HLD, 0, 0, 0, 1);
    cyc("R8 exit sec released", B_REL | B_SW, RUN, RUN, 1, 1, 0, 0);
    cyc("R8 standby refused",  B_REL | B_SBY, RUN, RUN, 0, 0, 0, 0);
    cyc("R4 pri stop rel0",    B_PST, STP, RUN, 0, 0, 0, 0);
    cyc("R10 sec stop",        B_SST, STP, STP, 0, 0, 0, 0);
    cyc("R8 standby both stop", B_SBY, STP, HLD, 0, 0, 0, 1);
    cyc("R8 exit to held",     B_PW,  RUN, HLD, 1, 0, 0, 0);
    cyc("R3 stop deferred",    B_REL | B_PST, RUN, RUN, 0, 1, 0, 0);
    cyc("R3 stop granted",     B_REL | B_PST, STP, RUN, 0, 0, 0, 0);
    cyc("R9 access not held",  B_ACC, STP, RUN, 0, 0, 0, 0);
    cyc("R1 reset strap",      B_RST | B_STRAP, RUN, HLD, 0, 0, 0, 0);
    cyc("R2 strap release",    B_STRAP, RUN, RUN, 0, 1, 0, 0);
    cyc("R4 R10 stop strap",   B_STRAP | B_PST | B_SST, STP, STP, 0, 0, 0, 0);
    cyc("R8 standby strap",    B_STRAP | B_SBY, STP, HLD, 0, 0, 0, 1);
    cyc("R9 R2 access strap",  B_STRAP | B_ACC, STP, HLD, 0, 0, 0, 1);
    cyc("R8 exit strap",       B_STRAP | B_PW, RUN, HLD, 1, 0, 0, 0);
    cyc("R2 strap after exit", B_STRAP, RUN, RUN, 0, 1, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule